// File: doc/BRIEF.md
# Hypervisor Debug and Monitor Trap Control

This block holds one 32-bit control word that a hypervisor programs. It also contains the combinational logic that uses that word to decide the fate of debug, trace and performance-monitor accesses made by guest software. Software at the hypervisor level, or at the top level in the non-secure state, reads and writes the word through a simple register port.

Every access request that reaches the block carries:
- the access class,
- the counter index, for counter accesses,
- the exception level and the security state of the requester.

For each request the block answers in the same cycle. It asserts `trap` when the access must be taken to the hypervisor. For a counter access it asserts `ctr_grant` when the counter may be used. Separately, a debug exception event is steered to the hypervisor through `route_to_hyp`.

Some trap bits have overrides. The global trap-general-exceptions input (`tge`) and the debug-exception trap bit can force the debug trap bits to act as 1. A read still returns the stored values. A 5-bit count field divides the implemented counters into a guest part and a hypervisor-only part. An illegal count gives the guest no counters.

The request path has no back-pressure. There is no ready signal. A request is decided in the cycle where `req_valid` is high, and it is never stalled. The register port is likewise single-cycle: writes land at the clock edge, and read data is combinational.

Top module: `hyp_dbg_trap_ctl`

## Requirements
- R1: Read data layout: bit 11 ROM-address debug trap, bit 10 OS-debug trap, bit 9 general-debug trap, bit 8 debug-exception trap, bit 7 hypervisor counter enable, bit 6 monitor-register trap, bit 5 monitor-control trap, bits 4:0 guest counter count. Bits 31:12 always read 0, whatever was written.
- R2: The register port is permitted only when `cfg_ns`=1 and `cfg_el` is 2 or 3 (levels encoded 0..3). Otherwise a write leaves the register unchanged, a read returns 0, and `cfg_denied` is 1 while `cfg_wr_en` or `cfg_rd_en` is high.
- R3: After reset, every trap bit reads 0 and the count reads 6. Bit 7 has no defined reset value.
- R4: `tge` and the debug-exception trap bit do not change the value read back.
- R5: A request traps the same cycle it arrives when `req_valid`=1, `req_ns`=1 and `req_el`<2, and it matches the rule for its class:
  - class 0 (ROM address) traps when its trap bit, `tge` or the debug-exception trap bit is 1;
  - class 1 (OS debug) traps under the same three conditions, using its own trap bit;
  - class 2 (other debug) traps under the same three conditions, using its own trap bit.
- R6: For monitor classes:
  - class 3 (monitor control) traps when the monitor-control trap bit or the monitor-register trap bit is 1;
  - classes 4 (monitor register) and 5 (counter) trap when the monitor-register trap bit is 1;
  - classes 6 and 7 never trap.
- R7: `trap` is 0 when `req_valid`=0, when `req_ns`=0, or when `req_el` is 2 or 3.
- R8: For class 5 from non-secure EL1, `ctr_grant`=1 exactly when the count is legal, index < count, and the request does not trap. EL0 additionally needs `user_en`=1.
- R9: For class 5 from non-secure EL2, `ctr_grant`=1 when index < NUM_CTR and either index < legal count or bit 7 is 1. Secure or EL3 requests are granted for index < NUM_CTR. An index ≥ NUM_CTR is never granted.
- R10: A count of 0 or above NUM_CTR is illegal. Lower levels then get no counter, and a read returns the written count.
- R11: `route_to_hyp`=1 exactly when `dbg_exc`=1, `req_ns`=1, `req_el`<2, and either the debug-exception trap bit or `tge` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_el | input | 2 | Exception level of the register accessor |
| cfg_ns | input | 1 | Non-secure state of the register accessor |
| cfg_rdata | output | 32 | Read data (0 when denied or idle) |
| cfg_denied | output | 1 | Register access refused |
| req_valid | input | 1 | Access request present |
| req_class | input | 3 | Access class code |
| req_ctr_idx | input | 5 | Counter index for class 5 |
| req_el | input | 2 | Requester exception level |
| req_ns | input | 1 | Requester non-secure state |
| tge | input | 1 | Global trap-general-exceptions flag |
| user_en | input | 1 | User-level counter access enable |
| dbg_exc | input | 1 | Debug exception event |
| trap | output | 1 | Trap the request to the hypervisor |
| ctr_grant | output | 1 | Counter access granted |
| route_to_hyp | output | 1 | Route the debug exception to the hypervisor |

## Verification
A corrupted stored bit shows up in two places. First, it appears on the next permitted read. Second, it appears in the same cycle as any lower-level request whose class depends on that bit, as a spurious or missing `trap`.

A wrong count or a wrong legality decision shows up in `ctr_grant`. It is visible at the boundary indices, count−1 and count, and at NUM_CTR. The bench walks those boundaries directly and also random configurations.

Override faults only appear when `tge` or the debug-exception trap bit is set while the individual trap bit is clear. Random stimulus covers that combination frequently.

// File: rtl/hdt_pkg.sv
package hdt_pkg;
  typedef enum logic [2:0] {
    CLS_DROM   = 3'd0,
    CLS_DOS    = 3'd1,
    CLS_DOTHER = 3'd2,
    CLS_PMCTL  = 3'd3,
    CLS_PMREG  = 3'd4,
    CLS_PMCTR  = 3'd5
  } acc_cls_e;

  localparam int CNT_W   = 5;
  localparam int CTL_W   = 12;
  localparam int WORD_W  = 32;

  typedef struct packed {
    logic             rom_trap;
    logic             os_trap;
    logic             dbg_trap;
    logic             exc_trap;
    logic             hyp_ctr_en;
    logic             mon_trap;
    logic             ctl_trap;
    logic [CNT_W-1:0] guest_cnt;
  } ctl_fields_t;
endpackage

// File: rtl/hdt_cfg_reg.sv
module hdt_cfg_reg
  import hdt_pkg::*;
#(
  parameter int RESET_CNT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic [1:0]        el,
  input  logic              ns,
  output logic [WORD_W-1:0] rdata,
  output logic              denied,
  output ctl_fields_t       fields
);
  localparam int PAD_W = WORD_W - CTL_W;

  logic        acc_ok;
  logic        wr_ok;
  ctl_fields_t wfld;
  ctl_fields_t stored;
  logic        ctr_en_q;

  assign acc_ok = ns && el[1];
  assign wr_ok  = wr_en && acc_ok;
  assign wfld   = ctl_fields_t'(wdata[CTL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored.rom_trap  <= 1'b0;
      stored.os_trap   <= 1'b0;
      stored.dbg_trap  <= 1'b0;
      stored.exc_trap  <= 1'b0;
      stored.mon_trap  <= 1'b0;
      stored.ctl_trap  <= 1'b0;
      stored.guest_cnt <= CNT_W'(RESET_CNT);
    end else if (wr_ok) begin
      stored.rom_trap  <= wfld.rom_trap;
      stored.os_trap   <= wfld.os_trap;
      stored.dbg_trap  <= wfld.dbg_trap;
      stored.exc_trap  <= wfld.exc_trap;
      stored.mon_trap  <= wfld.mon_trap;
      stored.ctl_trap  <= wfld.ctl_trap;
      stored.guest_cnt <= wfld.guest_cnt;
    end
  end

  // counter enable has no defined reset value
  always_ff @(posedge clk) begin
    if (wr_ok) ctr_en_q <= wfld.hyp_ctr_en;
  end

  always_comb begin
    fields            = stored;
    fields.hyp_ctr_en = ctr_en_q;
  end

  assign rdata  = (rd_en && acc_ok) ? {{PAD_W{1'b0}}, fields} : '0;
  assign denied = (wr_en || rd_en) && !acc_ok;

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[WORD_W-1:CTL_W] == '0);

  assert_denied_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && denied) |=> $stable(fields));
endmodule

// File: rtl/hdt_trap_decide.sv
module hdt_trap_decide
  import hdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctl_fields_t fields,
  input  logic        tge,
  input  logic        req_valid,
  input  logic [2:0]  req_class,
  input  logic [1:0]  req_el,
  input  logic        req_ns,
  input  logic        dbg_exc,
  output logic        trap,
  output logic        route_to_hyp
);
  logic     guest;
  logic     eff_exc;
  logic     dbg_force;
  acc_cls_e cls;
  logic     class_hit;

  assign guest     = req_ns && !req_el[1];
  assign eff_exc   = fields.exc_trap || tge;
  assign dbg_force = eff_exc;
  assign cls       = acc_cls_e'(req_class);

  always_comb begin
    unique case (cls)
      CLS_DROM:   class_hit = fields.rom_trap || dbg_force;
      CLS_DOS:    class_hit = fields.os_trap  || dbg_force;
      CLS_DOTHER: class_hit = fields.dbg_trap || dbg_force;
      CLS_PMCTL:  class_hit = fields.ctl_trap || fields.mon_trap;
      CLS_PMREG:  class_hit = fields.mon_trap;
      CLS_PMCTR:  class_hit = fields.mon_trap;
      default:    class_hit = 1'b0;
    endcase
  end

  assign trap         = req_valid && guest && class_hit;
  assign route_to_hyp = dbg_exc && guest && eff_exc;

  assert_lower_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (req_valid && req_ns && req_el < 2'd2));

  assert_tge_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ns && req_el < 2'd2 && tge && req_class <= 3'd2) |-> trap);

  assert_route_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    route_to_hyp |-> (dbg_exc && req_ns && (tge || fields.exc_trap)));
endmodule

// File: rtl/hdt_ctr_gate.sv
module hdt_ctr_gate
  import hdt_pkg::*;
#(
  parameter int NUM_CTR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_fields_t      fields,
  input  logic             req_valid,
  input  logic [2:0]       req_class,
  input  logic [CNT_W-1:0] req_ctr_idx,
  input  logic [1:0]       req_el,
  input  logic             req_ns,
  input  logic             user_en,
  input  logic             trap,
  output logic             ctr_grant
);
  localparam logic [CNT_W-1:0] N_CTR = CNT_W'(NUM_CTR);

  logic             cnt_legal;
  logic [CNT_W-1:0] guest_lim;
  logic             implemented;
  logic             in_guest;
  logic             is_ctr;

  assign cnt_legal   = (fields.guest_cnt != '0) && (fields.guest_cnt <= N_CTR);
  assign guest_lim   = cnt_legal ? fields.guest_cnt : '0;
  assign implemented = req_ctr_idx < N_CTR;
  assign in_guest    = req_ctr_idx < guest_lim;
  assign is_ctr      = req_valid && (req_class == CLS_PMCTR);

  always_comb begin
    ctr_grant = 1'b0;
    if (is_ctr && implemented) begin
      if (!req_ns || req_el == 2'd3)
        ctr_grant = 1'b1;
      else if (req_el == 2'd2)
        ctr_grant = in_guest || fields.hyp_ctr_en;
      else
        ctr_grant = in_guest && !trap && (req_el[0] || user_en);
    end
  end

  assert_grant_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_grant |-> !trap);

  assert_grant_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_grant |-> (req_ctr_idx < N_CTR && req_valid));

  assert_illegal_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_grant && req_ns && req_el < 2'd2) |->
      (fields.guest_cnt != '0 && fields.guest_cnt <= N_CTR));
endmodule

// File: rtl/hyp_dbg_trap_ctl.sv
module hyp_dbg_trap_ctl
  import hdt_pkg::*;
#(
  parameter int NUM_CTR   = 8,
  parameter int RESET_CNT = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic        cfg_rd_en,
  input  logic [31:0] cfg_wdata,
  input  logic [1:0]  cfg_el,
  input  logic        cfg_ns,
  output logic [31:0] cfg_rdata,
  output logic        cfg_denied,
  input  logic        req_valid,
  input  logic [2:0]  req_class,
  input  logic [4:0]  req_ctr_idx,
  input  logic [1:0]  req_el,
  input  logic        req_ns,
  input  logic        tge,
  input  logic        user_en,
  input  logic        dbg_exc,
  output logic        trap,
  output logic        ctr_grant,
  output logic        route_to_hyp
);
  ctl_fields_t fields;
  logic        trap_w;

  hdt_cfg_reg #(.RESET_CNT(RESET_CNT)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .rd_en  (cfg_rd_en),
    .wdata  (cfg_wdata),
    .el     (cfg_el),
    .ns     (cfg_ns),
    .rdata  (cfg_rdata),
    .denied (cfg_denied),
    .fields (fields)
  );

  hdt_trap_decide u_trap (
    .clk          (clk),
    .rst_n        (rst_n),
    .fields       (fields),
    .tge          (tge),
    .req_valid    (req_valid),
    .req_class    (req_class),
    .req_el       (req_el),
    .req_ns       (req_ns),
    .dbg_exc      (dbg_exc),
    .trap         (trap_w),
    .route_to_hyp (route_to_hyp)
  );

  hdt_ctr_gate #(.NUM_CTR(NUM_CTR)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .fields      (fields),
    .req_valid   (req_valid),
    .req_class   (req_class),
    .req_ctr_idx (req_ctr_idx),
    .req_el      (req_el),
    .req_ns      (req_ns),
    .user_en     (user_en),
    .trap        (trap_w),
    .ctr_grant   (ctr_grant)
  );

  assign trap = trap_w;
endmodule

// File: tb/hyp_dbg_trap_ctl_tb.sv
`timescale 1ns/1ps
module hyp_dbg_trap_ctl_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 0, cfg_rd_en = 0, cfg_ns = 0;
  logic [31:0] cfg_wdata = 0;
  logic [1:0] cfg_el = 0;
  logic [31:0] cfg_rdata;
  logic cfg_denied;
  logic req_valid = 0, req_ns = 0, tge = 0, user_en = 0, dbg_exc = 0;
  logic [2:0] req_class = 0;
  logic [4:0] req_ctr_idx = 0;
  logic [1:0] req_el = 0;
  logic trap, ctr_grant, route_to_hyp;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [11:0] m_reg;

  always #4 clk = ~clk;

  hyp_dbg_trap_ctl #(.NUM_CTR(N)) u_dut (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v, input logic [1:0] el, input logic ns);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wdata = v; cfg_el = el; cfg_ns = ns;
    @(negedge clk);
    cfg_wr_en = 0;
    if (ns && el[1]) m_reg = v[11:0];
  endtask

  task automatic rd(input logic [1:0] el, input logic ns, output logic [31:0] v, output logic den);
    @(negedge clk);
    cfg_rd_en = 1; cfg_el = el; cfg_ns = ns;
    #1 v = cfg_rdata; den = cfg_denied;
    cfg_rd_en = 0;
  endtask

  function automatic logic f_trap(logic v, logic [2:0] c, logic [1:0] el, logic ns, logic g);
    logic frc;
    if (!v || !ns || el >= 2) return 0;
    frc = g | m_reg[8];
    case (c)
      3'd0: return m_reg[11] | frc;
      3'd1: return m_reg[10] | frc;
      3'd2: return m_reg[9] | frc;
      3'd3: return m_reg[5] | m_reg[6];
      3'd4, 3'd5: return m_reg[6];
      default: return 0;
    endcase
  endfunction

  function automatic logic f_grant(logic v, logic [2:0] c, logic [4:0] idx, logic [1:0] el,
                                   logic ns, logic g, logic ue);
    int lim;
    if (!v || c != 3'd5 || idx >= N) return 0;
    if (!ns || el == 3) return 1;
    lim = (m_reg[4:0] != 0 && m_reg[4:0] <= N) ? int'(m_reg[4:0]) : 0;
    if (el == 2) return (idx < lim) || m_reg[7];
    if (f_trap(v, c, el, ns, g)) return 0;
    return (idx < lim) && (el == 1 || ue);
  endfunction

  task automatic req(input logic v, input logic [2:0] c, input logic [4:0] idx, input logic [1:0] el,
                     input logic ns, input logic g, input logic ue, input logic de, input string tag);
    @(negedge clk);
    req_valid = v; req_class = c; req_ctr_idx = idx; req_el = el; req_ns = ns;
    tge = g; user_en = ue; dbg_exc = de;
    #1;
    check(trap, f_trap(v, c, el, ns, g), {tag, " trap R5 R6 R7"});
    check(ctr_grant, f_grant(v, c, idx, el, ns, g, ue), {tag, " grant R8 R9 R10"});
    check(route_to_hyp, de && ns && el < 2 && (m_reg[8] | g), {tag, " route R11"});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic den;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset values (bit 7 masked)
    rd(2'd2, 1'b1, rv, den);
    check(rv & 32'hFFFF_FF7F, 32'h6, "R3 reset value");
    m_reg = 12'h006;
    wr(32'h0000_0006, 2'd2, 1'b1);
    // R1 reserved bits and layout
    wr(32'hFFFF_FFFF, 2'd2, 1'b1);
    rd(2'd3, 1'b1, rv, den);
    check(rv, 32'h0000_0FFF, "R1 reserved read zero");
    // R2 denied write/read
    wr(32'h0000_0A05, 2'd1, 1'b1);
    wr(32'h0000_0A05, 2'd3, 1'b0);
    rd(2'd1, 1'b1, rv, den);
    check(rv, 32'h0, "R2 denied read data");
    check(den, 1'b1, "R2 denied flag");
    rd(2'd2, 1'b1, rv, den);
    check(rv, 32'h0000_0FFF, "R2 denied write ignored");
    check(den, 1'b0, "R2 permitted flag");
    // R4 overrides do not change readback
    wr(32'h0000_0103, 2'd2, 1'b1);
    tge = 1;
    rd(2'd2, 1'b1, rv, den);
    check(rv, 32'h0000_0103, "R4 readback under overrides");
    tge = 0;
    // R5 forcing via debug-exception trap bit and tge
    req(1, 3'd0, 0, 2'd1, 1, 0, 0, 1, "R5 exc bit forces rom");
    wr(32'h0000_0003, 2'd2, 1'b1);
    req(1, 3'd1, 0, 2'd0, 1, 1, 0, 1, "R5 tge forces os");
    req(1, 3'd2, 0, 2'd0, 1, 0, 0, 0, "R5 clear no trap");
    // R7 secure and EL2 never trap
    wr(32'h0000_0E63, 2'd2, 1'b1);
    req(1, 3'd0, 0, 2'd2, 1, 1, 0, 0, "R7 EL2");
    req(1, 3'd4, 0, 2'd1, 0, 1, 0, 0, "R7 secure");
    req(0, 3'd4, 0, 2'd1, 1, 1, 0, 0, "R7 not valid");
    // R8 boundaries, count 3
    wr(32'h0000_0003, 2'd2, 1'b1);
    req(1, 3'd5, 5'd2, 2'd1, 1, 0, 0, 0, "R8 idx cnt-1");
    req(1, 3'd5, 5'd3, 2'd1, 1, 0, 0, 0, "R8 idx cnt");
    req(1, 3'd5, 5'd0, 2'd0, 1, 0, 0, 0, "R8 EL0 no user");
    req(1, 3'd5, 5'd0, 2'd0, 1, 0, 1, 0, "R8 EL0 user");
    // R9 EL2 with hyp enable, and N boundary
    wr(32'h0000_0083, 2'd2, 1'b1);
    req(1, 3'd5, 5'd7, 2'd2, 1, 0, 0, 0, "R9 EL2 top counter");
    req(1, 3'd5, 5'd8, 2'd2, 1, 0, 0, 0, "R9 idx N");
    // R10 illegal counts
    wr(32'h0000_001F, 2'd2, 1'b1);
    rd(2'd2, 1'b1, rv, den);
    check(rv, 32'h0000_001F, "R10 readback as written");
    req(1, 3'd5, 5'd0, 2'd1, 1, 0, 1, 0, "R10 cnt 31");
    wr(32'h0000_0000, 2'd2, 1'b1);
    req(1, 3'd5, 5'd0, 2'd0, 1, 0, 1, 0, "R10 cnt 0");
    req(1, 3'd5, 5'd0, 2'd2, 1, 0, 0, 0, "R10 EL2 cnt 0");
    // random
    for (int i = 0; i < 400; i++) begin
      if (i % 20 == 0) begin
        wr($urandom, 2'd2 + 2'($urandom % 2), 1'b1);
        rd(2'd2, 1'b1, rv, den);
        check(rv, {20'h0, m_reg}, "R1 R4 random readback");
      end
      req(1'($urandom % 8 != 0), 3'($urandom), 5'($urandom % 12), 2'($urandom),
          1'($urandom % 4 != 0), 1'($urandom % 4 == 0), 1'($urandom),
          1'($urandom), "random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule